// File: doc/BRIEF.md
# Dual-Order Burst Address Counter

This block produces the two least significant address bits of a burst access to a synchronous burst memory. When a new access is accepted, the starting low address bits are captured. On every later clock edge where the advance enable is asserted, the output moves to the next position of the burst. After four positions it returns to the starting value.

Two burst orderings are generated from one sequence count. In interleaved order the output is the starting value XORed with the count. In linear order the output is the starting value plus the count, wrapping within the burst. A static order-select input chooses between them. When neither a load nor an advance is requested, the output holds its value, which suspends the burst.

Upper address bits, storage, chip-select decoding and data control live elsewhere. The surrounding address register supplies the strobe that drives `load`.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears, and after that edge `burst_addr` reads 00.
- R2: A rising edge with `load` high makes `burst_addr` equal to the `start_addr` value sampled at that edge, in either order.
- R3: If `load` and an advance (`adv_n` low) occur at the same edge, the load wins: the output equals the new start value and the burst restarts at its first position.
- R4: With `order_sel` high (interleaved), the k-th advance after a load from start S gives S XOR k. For example, from 01 the sequence is 01,00,11,10, and from 11 it is 11,10,01,00.
- R5: With `order_sel` low (linear), the k-th advance after a load from start S gives (S + k) mod 4. For example, from 01 the sequence is 01,10,11,00, and from 11 it is 11,00,01,10.
- R6: An edge with `load` low and `adv_n` high leaves `burst_addr` unchanged (burst suspend).
- R7: Four advances after a load bring `burst_addr` back to the start value. Further advances repeat the same four-address cycle.
- R8: Advances issued after reset with no load step the burst from start 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Capture `start_addr` and restart the burst |
| start_addr | input | BURST_W (2) | Starting low address bits |
| adv_n | input | 1 | Advance to the next burst position, active low |
| order_sel | input | 1 | Static order choice: 1 interleaved, 0 linear |
| burst_addr | output | BURST_W (2) | Current burst address bits |

## Verification
The hardest case to reach is a load and an advance arriving at the same edge in the middle of a burst. In that case the stale count must be dropped and not stepped. The stimulus reaches this case by first advancing partway into a burst and then asserting both strobes in one cycle. It then checks that the following advances start again from the first position. The wrap back to the start is reached by running more than four advances from every start value in both orders. A suspend run holds `adv_n` high over several edges between advances.

// File: rtl/burst_addr_pkg.sv
// Package: shared width and order encoding for the burst address counter.
// Assumes: bursts are a power-of-two length of 2**BURST_W positions.
package burst_addr_pkg;
    localparam int BURST_W = 2;
    localparam int BURST_LEN = 1 << BURST_W;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_start_reg.sv
// Module: holds the starting low address bits of the current burst.
// Assumes: load is already qualified by the address strobe logic upstream.
module burst_start_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] start_in,
    output logic [W-1:0] start_q
);
    // Capture the start address on a load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else if (load)
            start_q <= start_in;
    end

    // R2: a load edge makes the captured start equal the sampled input.
    assert_start_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (start_q == $past(start_in)));
endmodule

// File: rtl/burst_seq_count.sv
// Module: wrapping sequence count giving the position within the burst.
// Assumes: a load restarts the burst and takes priority over an advance.
module burst_seq_count #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv_n,
    output logic [W-1:0] count_q
);
    // Clear on reset or load, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= '0;
        else if (!adv_n)
            count_q <= count_q + W'(1);
    end

    // R3: a load clears the position even when an advance is present.
    assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == '0));

    // R7: each advance steps the position by one, wrapping at the burst end.
    assert_count_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n) |=> (count_q == W'($past(count_q) + W'(1))));
endmodule

// File: rtl/burst_order_map.sv
// Module: maps start address and burst position onto the output address.
// Assumes: order select is static for the length of a burst.
module burst_order_map #(
    parameter int W = 2
) (
    input  logic         order_sel,
    input  logic [W-1:0] start_q,
    input  logic [W-1:0] count_q,
    output logic [W-1:0] addr_out
);
    import burst_addr_pkg::*;

    // Select XOR (interleaved) or modular sum (linear) of start and position.
    always_comb begin
        if (burst_order_e'(order_sel) == ORDER_INTERLEAVE)
            addr_out = start_q ^ count_q;
        else
            addr_out = start_q + count_q;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: top of the dual-order burst address counter.
// Assumes: load comes from an accepted address strobe; adv_n is active low;
// order_sel is tied static (1 interleaved, 0 linear).
module burst_addr_gen #(
    parameter int BURST_W = burst_addr_pkg::BURST_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BURST_W-1:0] start_addr,
    input  logic               adv_n,
    input  logic               order_sel,
    output logic [BURST_W-1:0] burst_addr
);
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] count_q;

    burst_start_reg #(.W(BURST_W)) u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .start_in (start_addr),
        .start_q  (start_q)
    );

    burst_seq_count #(.W(BURST_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .adv_n   (adv_n),
        .count_q (count_q)
    );

    burst_order_map #(.W(BURST_W)) u_map (
        .order_sel (order_sel),
        .start_q   (start_q),
        .count_q   (count_q),
        .addr_out  (burst_addr)
    );

    // R1: a reset edge leaves the output at zero.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (burst_addr == '0));

    // R2: after a load the port shows the sampled start value.
    assert_load_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (burst_addr == $past(start_addr)));

    // R6: with no load and no advance the output is held.
    assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> ($stable(burst_addr) || !$stable(order_sel)));

    // R5: in linear order each advance adds one to the output.
    assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && !order_sel) |=>
            ((burst_addr == BURST_W'($past(burst_addr) + BURST_W'(1))) || !$stable(order_sel)));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] start_addr = '0;
    logic         adv_n = 1'b1;
    logic         order_sel = 1'b1;
    logic [W-1:0] burst_addr;

    int checks = 0;
    int failures = 0;

    // Behavioural reference state.
    int ref_start = 0;
    int ref_pos = 0;

    burst_addr_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (start_addr),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .burst_addr (burst_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int expected_addr();
        if (order_sel)
            return ref_start ^ ref_pos;
        return (ref_start + ref_pos) % 4;
    endfunction

    task automatic check(input string tag, input int exp_v);
        checks++;
        if (int'(burst_addr) != exp_v) begin
            failures++;
            $display("FAIL %s: burst_addr=%0d expected=%0d", tag, burst_addr, exp_v);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input logic ld, input int st, input logic advn, input string tag);
        load = ld;
        start_addr = W'(st);
        adv_n = advn;
        @(posedge clk);
        if (!rst_n) begin
            ref_start = 0;
            ref_pos = 0;
        end else if (ld) begin
            ref_start = st;
            ref_pos = 0;
        end else if (!advn) begin
            ref_pos = (ref_pos + 1) % 4;
        end
        @(negedge clk);
        check(tag, expected_addr());
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset clears the output even with a load requested.
        step(1'b1, 3, 1'b0, "R1");
        step(1'b0, 2, 1'b1, "R1");
        check("R1", 0);
        rst_n = 1'b1;

        // R8: advance from reset without any load.
        order_sel = 1'b0;
        for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b0, "R8");
        check("R8", 3);

        // R4 and R7: interleaved order from every start, past the wrap.
        order_sel = 1'b1;
        for (int s = 0; s < 4; s++) begin
            step(1'b1, s, 1'b1, "R2");
            check("R2", s);
            for (int k = 1; k <= 6; k++) begin
                step(1'b0, 0, 1'b0, "R4");
                check("R4", s ^ (k % 4));
                if (k == 4) check("R7", s);
            end
        end

        // R5 and R7: linear order from every start, past the wrap.
        order_sel = 1'b0;
        for (int s = 0; s < 4; s++) begin
            step(1'b1, s, 1'b1, "R2");
            for (int k = 1; k <= 6; k++) begin
                step(1'b0, 0, 1'b0, "R5");
                check("R5", (s + k) % 4);
                if (k == 4) check("R7", s);
            end
        end

        // R6: suspend in both orders, inputs on start_addr must not matter.
        for (int o = 0; o < 2; o++) begin
            order_sel = o[0];
            step(1'b1, 1, 1'b1, "R2");
            step(1'b0, 0, 1'b0, "R6");
            for (int k = 0; k < 3; k++) begin
                step(1'b0, 3 - k, 1'b1, "R6");
                check("R6", o == 1 ? 0 : 2);
            end
            step(1'b0, 0, 1'b0, "R6");
            check("R6", o == 1 ? 3 : 3);
        end

        // R3: load together with advance mid-burst restarts at the new start.
        order_sel = 1'b1;
        step(1'b1, 2, 1'b1, "R3");
        step(1'b0, 0, 1'b0, "R3");
        step(1'b0, 0, 1'b0, "R3");
        step(1'b1, 1, 1'b0, "R3");
        check("R3", 1);
        step(1'b0, 0, 1'b0, "R3");
        check("R3", 0);
        order_sel = 1'b0;
        step(1'b1, 3, 1'b0, "R3");
        check("R3", 3);
        step(1'b0, 0, 1'b0, "R3");
        check("R3", 0);

        // R1: reset mid-burst returns to zero.
        step(1'b0, 0, 1'b0, "R1");
        rst_n = 1'b0;
        step(1'b0, 0, 1'b0, "R1");
        check("R1", 0);
        rst_n = 1'b1;
        step(1'b0, 0, 1'b1, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule